// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Register

This block holds the interrupt status word of an Ethernet-style DMA engine. The transmit and receive DMA paths send single-cycle event pulses, and each pulse sets a sticky flag. Software reads the word and clears any flag by writing 1 to its position. Two further sticky bits summarise the flags. The normal summary covers transmit-done, transmit-buffer-unavailable, receive-done and early-receive. The abnormal summary covers the error and stall events. A flag counts toward its summary only when its bit is set in a separate enable word. The enable word is an input, and it uses the same bit positions as the status word.

The interrupt request line is driven from the two summary bits, each gated by its own enable. When a fatal bus error is flagged, a bus-off output tells the DMA to stop all bus transactions. The early-receive flag clears itself when a receive completes.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every status bit reads 0. An event pulse on `evt_i[b]` for an event bit b (0..10, 13, 14) sets status bit b, and the new value reads back one cycle after the pulse.
- R2: A write with `wr_en_i` high clears every status bit whose `wr_data_i` bit is 1. Bits written with 0 keep their value.
- R3: When an event pulse and a write-1 clear hit the same event bit in the same cycle, the bit stays set.
- R4: Normal summary (bit 16) sets one cycle after any status bit 0, 2, 6 or 14 is 1 while the matching `en_i` bit is 1. Bits whose enable is 0 have no effect on it.
- R5: Abnormal summary (bit 15) sets one cycle after any status bit 1, 3, 4, 5, 7, 8, 9, 10 or 13 is 1 while the matching `en_i` bit is 1. Bits whose enable is 0 have no effect on it.
- R6: Each summary bit stays set until a write-1 to its position, even after its source flags have been cleared. A write-1 clears it only in a cycle in which no enabled flag of its group is set.
- R7: Early receive (bit 14) is held at 0 in any cycle in which the receive-done flag (bit 6) is set or a receive-done pulse arrives. This holds even if an early-receive pulse arrives in the same cycle.
- R8: `bus_off_o` is 1 exactly while the fatal bus error flag (bit 13) is set.
- R9: Bits 11, 12 and 17..31 always read 0. Pulses and writes to those positions have no effect.
- R10: `irq_o` = (bit 16 AND `en_i[16]`) OR (bit 15 AND `en_i[15]`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | Event pulses, one per status position |
| wr_en_i | input | 1 | Write strobe for write-1-to-clear |
| wr_data_i | input | 32 | Write data; 1 bits clear |
| en_i | input | 32 | Interrupt enable word, same layout as status |
| rd_data_o | output | 32 | Current status word |
| irq_o | output | 1 | Interrupt request |
| bus_off_o | output | 1 | Disable DMA bus access |

## Verification
An event pulse that sets a flag can arrive in the same cycle as a software write-1 clear of that flag. A summary's set condition can also coincide with a write-1 clear of the summary. The table provokes both. One row pulses transmit-done while writing 1 to bit 0. Other rows write 1 to a summary bit while its source flag is still set, and then again after the flag has gone. The row is judged by the status word read one cycle later: the flag and the summary must survive the collision, and the summary must drop only on the later write.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned EVT_W  = 16;

  localparam int unsigned B_TXD  = 0;
  localparam int unsigned B_RXD  = 6;
  localparam int unsigned B_FBE  = 13;
  localparam int unsigned B_ERX  = 14;
  localparam int unsigned B_ABN  = 15;
  localparam int unsigned B_NRM  = 16;

  localparam logic [STAT_W-1:0] NRM_GRP = 32'h0000_4045;
  localparam logic [STAT_W-1:0] ABN_GRP = 32'h0000_27BA;
  localparam logic [STAT_W-1:0] EVT_GRP = NRM_GRP | ABN_GRP;

  function automatic logic grp_active(input logic [STAT_W-1:0] flags,
                                      input logic [STAT_W-1:0] en,
                                      input logic [STAT_W-1:0] grp);
    return |(flags & en & grp);
  endfunction

  function automatic logic sticky_next(input logic q, input logic set,
                                       input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int unsigned EW = EVT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] evt_i,
  input  logic [EW-1:0] clr_i,
  output logic [EW-1:0] flags_o
);
  logic erx_hold;
  assign erx_hold = flags_o[B_RXD] | evt_i[B_RXD];

  for (genvar b = 0; b < EW; b++) begin : g_bit
    if (EVT_GRP[b]) begin : g_ff
      logic q_r;
      logic hold_b;
      if (b == B_ERX) begin : g_erx
        assign hold_b = erx_hold;
      end else begin : g_plain
        assign hold_b = 1'b0;
      end
      always_ff @(posedge clk) begin
        if (!rst_n)      q_r <= 1'b0;
        else if (hold_b) q_r <= 1'b0;
        else             q_r <= sticky_next(q_r, evt_i[b], clr_i[b]);
      end
      assign flags_o[b] = q_r;

      if (b != B_ERX) begin : g_chk
        // R3
        evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
          evt_i[b] |=> q_r);
      end
    end else begin : g_rsv
      assign flags_o[b] = 1'b0;
    end
  end

  // R7
  erx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[B_RXD] |-> !flags_o[B_ERX]);
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic sum_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) sum_o <= 1'b0;
    else        sum_o <= dma_irq_pkg::sticky_next(sum_o, set_i, clr_i);
  end

  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_o && !clr_i) |=> sum_o);
  // R6
  sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !sum_o);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int unsigned SW = STAT_W,
  parameter int unsigned EW = EVT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] evt_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_data_i,
  input  logic [SW-1:0] en_i,
  output logic [SW-1:0] rd_data_o,
  output logic          irq_o,
  output logic          bus_off_o
);
  logic [EW-1:0] flag_clr;
  logic [EW-1:0] flags;
  logic [SW-1:0] flags_w;
  logic          nrm_set, abn_set, nrm_clr, abn_clr;
  logic          nrm_sum, abn_sum;

  assign flag_clr = wr_en_i ? wr_data_i[EW-1:0] : '0;

  dma_irq_flags #(.EW(EW)) i_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (flag_clr),
    .flags_o(flags)
  );

  always_comb begin
    flags_w         = '0;
    flags_w[EW-1:0] = flags;
  end

  assign nrm_set = grp_active(flags_w, en_i, NRM_GRP);
  assign abn_set = grp_active(flags_w, en_i, ABN_GRP);
  assign nrm_clr = wr_en_i & wr_data_i[B_NRM];
  assign abn_clr = wr_en_i & wr_data_i[B_ABN];

  dma_irq_summary i_nrm (
    .clk(clk), .rst_n(rst_n), .set_i(nrm_set), .clr_i(nrm_clr), .sum_o(nrm_sum)
  );
  dma_irq_summary i_abn (
    .clk(clk), .rst_n(rst_n), .set_i(abn_set), .clr_i(abn_clr), .sum_o(abn_sum)
  );

  always_comb begin
    rd_data_o        = flags_w;
    rd_data_o[B_ABN] = abn_sum;
    rd_data_o[B_NRM] = nrm_sum;
  end

  assign irq_o     = (nrm_sum & en_i[B_NRM]) | (abn_sum & en_i[B_ABN]);
  assign bus_off_o = flags[B_FBE];

  // R8
  bus_off_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[B_FBE] |=> bus_off_o);
  // R4
  nrm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_set |=> rd_data_o[B_NRM]);
  // R5
  abn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abn_set |=> rd_data_o[B_ABN]);
  // R9
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_i[12:11] != 2'b00) |-> (rd_data_o[12:11] == 2'b00));
endmodule

// File: tb/test_dma_irq_status.sv
module test_dma_irq_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic        we;
  logic [31:0] wd, en, rd;
  logic        irq, boff;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  dma_irq_status i_dma_irq_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(we), .wr_data_i(wd),
    .en_i(en), .rd_data_o(rd), .irq_o(irq), .bus_off_o(boff)
  );

  typedef struct packed {
    logic [15:0] evt;
    logic        we;
    logic [31:0] wd;
    logic [31:0] en;
    logic [31:0] rd;
    logic        irq;
    logic        boff;
    logic [7:0]  req;
  } vec_t;

  localparam int N = 17;
  localparam vec_t TBL [N] = '{
    '{16'h0001, 1'b0, 32'h0,        32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 8'd1},  // R1 set
    '{16'h0000, 1'b0, 32'h0,        32'hFFFFFFFF, 32'h00010001, 1'b1, 1'b0, 8'd4},  // R4 summary
    '{16'h0000, 1'b1, 32'h1,        32'hFFFFFFFF, 32'h00010000, 1'b1, 1'b0, 8'd6},  // R6 sticky
    '{16'h0000, 1'b1, 32'h10000,    32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0, 8'd6},  // R6 clear
    '{16'h0002, 1'b0, 32'h0,        32'hFFFFFFFD, 32'h00000002, 1'b0, 1'b0, 8'd1},  // R1
    '{16'h0000, 1'b0, 32'h0,        32'hFFFFFFFD, 32'h00000002, 1'b0, 1'b0, 8'd5},  // R5 masked
    '{16'h2000, 1'b0, 32'h0,        32'hFFFFFFFD, 32'h00002002, 1'b0, 1'b1, 8'd8},  // R8
    '{16'h0000, 1'b0, 32'h0,        32'hFFFFFFFD, 32'h0000A002, 1'b1, 1'b1, 8'd5},  // R5
    '{16'h0000, 1'b1, 32'h0,        32'hFFFF7FFD, 32'h0000A002, 1'b0, 1'b1, 8'd10}, // R10, R2 zero write
    '{16'h0040, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00008040, 1'b1, 1'b0, 8'd6},  // R6
    '{16'h4000, 1'b1, 32'h8000,     32'hFFFFFFFF, 32'h00010040, 1'b1, 1'b0, 8'd7},  // R7
    '{16'h0000, 1'b1, 32'h10040,    32'hFFFFFFFF, 32'h00010000, 1'b1, 1'b0, 8'd6},  // R6
    '{16'h0000, 1'b1, 32'h10000,    32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0, 8'd2},  // R2
    '{16'h4000, 1'b0, 32'h0,        32'hFFFFFFFF, 32'h00004000, 1'b0, 1'b0, 8'd1},  // R1
    '{16'h0040, 1'b0, 32'h0,        32'hFFFFFFFF, 32'h00010040, 1'b1, 1'b0, 8'd7},  // R7
    '{16'h1800, 1'b1, 32'hFFFE1800, 32'hFFFFFFFF, 32'h00010040, 1'b1, 1'b0, 8'd9},  // R9
    '{16'h0001, 1'b1, 32'h1,        32'hFFFFFFFF, 32'h00010041, 1'b1, 1'b0, 8'd3}   // R3
  };

  task automatic chk32(input logic [31:0] act, input logic [31:0] exp,
                       input int r, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; we = 1'b0; wd = '0; en = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk32(rd, 32'h0, 1, "reset status");
    chk32({31'b0, irq}, 32'h0, 10, "reset irq");
    chk32({31'b0, boff}, 32'h0, 8, "reset bus_off");

    for (int i = 0; i < N; i++) begin
      evt = TBL[i].evt; we = TBL[i].we; wd = TBL[i].wd; en = TBL[i].en;
      @(posedge clk);
      @(negedge clk);
      chk32(rd, TBL[i].rd, int'(TBL[i].req), $sformatf("row %0d status", i));
      chk32({31'b0, irq}, {31'b0, TBL[i].irq}, 10, $sformatf("row %0d irq", i));
      chk32({31'b0, boff}, {31'b0, TBL[i].boff}, 8, $sformatf("row %0d bus_off", i));
    end

    // R7 directed: early-receive and receive-done pulses together, flags clear
    evt = 16'h0000; we = 1'b1; wd = 32'hFFFFFFFF;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk32(rd, 32'h0, 6, "cleared before collision");
    we = 1'b0; evt = 16'h4040;
    @(posedge clk); @(negedge clk);
    chk32(rd & 32'h0000FFFF, 32'h00000040, 7, "early rx with rx done");

    // R1 reset clears everything mid-run
    evt = '0; rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk32(rd, 32'h0, 1, "status after second reset");
    done = 1'b1;
    finish_run();
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule